// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Driver-Enable Timing

This block serialises characters onto an asynchronous line for a shared, half-duplex bus such as an RS-485 pair. Around every character it raises a driver-enable output for the line transceiver. It holds that output high for a programmable number of oversampling ticks before the start bit, and keeps it high for a second programmable number of ticks after the final stop bit. All frame timing advances on a one-clock tick pulse that the surrounding logic supplies at the oversampling rate.

Characters enter through a valid/ready port that holds one pending character. A character can be accepted while the transmitter is idle or while the trailing enable delay is running. A character accepted during the trailing delay is not appended to the previous frame. The enable output first drops, and the new frame then goes through a full leading delay. The frame settings are word length, ticks per bit, stop-bit count and the two delays. They are captured only while the block is disabled, so software cannot alter a frame that is in flight.

Top module: `uart_de_tx`

## Requirements
- R1: While reset is applied and directly after reset: `tx` = 1, `de` = 0 and `tx_busy` = 0. While `enable` = 0, `wr_ready` = 0.
- R2: A frame is made of one start bit at 0, then data bits sent least significant bit first, then stop bits at 1. The word-length code `cfg_wlen` selects the number of data bits: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 7, and 2'b11 gives 8. Data bit i is `wr_data[i]`, and bits above the selected length are never sent.
- R3: `cfg_os8` = 0 makes each bit last 16 ticks. `cfg_os8` = 1 makes each bit last 8 ticks.
- R4: `cfg_stop2` = 0 sends one stop bit. `cfg_stop2` = 1 sends two stop bits.
- R5: `de` rises `cfg_lead` ticks before the start bit begins. `tx` stays 1 during that interval. With `cfg_lead` = 0, `de` rises in the same clock in which `tx` falls for the start bit.
- R6: `de` stays high for `cfg_lag` ticks after the last stop bit ends. With `cfg_lag` = 0, `de` falls when the last stop bit ends. While `de` = 0, `tx` = 1.
- R7: A character offered during the trailing delay is accepted. The trailing delay still runs to its end, then `de` goes low for at least one clock, and the new frame then gets its full leading delay.
- R8: `wr_ready` = 1 only when `enable` = 1, no character is pending, and the transmitter is idle or in its trailing delay. At most one character is pending.
- R9: The word length, ticks per bit, stop count and both delays are taken from the inputs only while `enable` = 0. Changes made while `enable` = 1 have no effect on frames.
- R10: `tx_busy` is high exactly while `de` is high.
- R11: Driving `enable` to 0 aborts any frame. From the next clock, `tx` = 1 and `de` = 0, and the pending character is discarded.
- R12: The leading delay, the bit timing and the trailing delay advance only on clocks where `tick` = 1. While `tick` = 0, the line and `de` hold their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Block enable; while low, the configuration is captured and any frame is aborted |
| tick | input | 1 | One-clock pulse at the oversampling rate |
| cfg_wlen | input | 2 | Word-length code (00: 8, 01: 9, 10: 7, 11: 8 data bits) |
| cfg_os8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| cfg_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_lead | input | 5 | Ticks of `de` before the start bit |
| cfg_lag | input | 5 | Ticks of `de` after the last stop bit |
| wr_valid | input | 1 | Character offered |
| wr_ready | output | 1 | Character accepted on this clock when `wr_valid` is high |
| wr_data | input | 9 | Character, LSB sent first |
| tx | output | 1 | Serial line, idles at 1 |
| de | output | 1 | Line-driver enable |
| tx_busy | output | 1 | High while `de` is high |

## Verification
The hardest situation to reach is a write that lands inside the trailing delay of a frame. The frame must be far enough along that its stop bits have ended, while `de` is still high. The bench runs the tick every clock, so ticks and clocks coincide. It counts clocks from the falling edge of the start bit, offers the second character exactly on the first clock of the trailing delay, and keeps counting to confirm three things: the trailing delay was not cut short, `de` dropped, and the second frame was preceded by a complete leading delay. Holding `tick` low with a character already accepted shows that the leading delay freezes rather than running on the clock.

// File: rtl/uart_de_pkg.sv
// Shared definitions for the driver-enable serial transmitter.
// Assumes: data is at most 9 bits wide; word-length codes are fixed by the spec.
package uart_de_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_LAG
    } seq_state_t;

    // Map the two-bit word-length code to a data-bit count (11 treated as 8)
    function automatic int unsigned wlen_to_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 9;
            2'b10:   return 7;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_de_cfg.sv
// Configuration capture: follows the raw inputs while the block is disabled
// and freezes them while it is enabled.
// Assumes: rst_n is synchronous, active low.
module uart_de_cfg #(
    parameter int DLY_W = 5,
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       raw_wlen,
    input  logic             raw_os8,
    input  logic             raw_stop2,
    input  logic [DLY_W-1:0] raw_lead,
    input  logic [DLY_W-1:0] raw_lag,
    output logic [1:0]       wlen_q,
    output logic             os8_q,
    output logic             stop2_q,
    output logic [DLY_W-1:0] lead_q,
    output logic [DLY_W-1:0] lag_q,
    output logic [BIT_W-1:0] nbits
);
    import uart_de_pkg::*;

    // Capture the settings only while enable is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlen_q  <= 2'b00;
            os8_q   <= 1'b0;
            stop2_q <= 1'b0;
            lead_q  <= '0;
            lag_q   <= '0;
        end else if (!enable) begin
            wlen_q  <= raw_wlen;
            os8_q   <= raw_os8;
            stop2_q <= raw_stop2;
            lead_q  <= raw_lead;
            lag_q   <= raw_lag;
        end
    end

    // Decode the data-bit count from the captured code
    always_comb begin
        nbits = BIT_W'(wlen_to_bits(wlen_q));
    end

endmodule

// File: rtl/uart_de_hold.sv
// One-entry holding register between the write port and the sequencer.
// Assumes: push is only raised when the entry is empty; disable clears it.
module uart_de_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              vld,
    output logic [DATA_W-1:0] data
);

    // Track occupancy of the single pending slot
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            vld <= 1'b0;
        end else if (push) begin
            vld <= 1'b1;
        end else if (pop) begin
            vld <= 1'b0;
        end
    end

    // Store the pending character on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (push) begin
            data <= push_data;
        end
    end

endmodule

// File: rtl/uart_de_seq.sv
// Frame sequencer: leading enable delay, start bit, data bits (LSB first),
// stop bits and trailing enable delay, all stepped by the oversampling tick.
// Assumes: configuration inputs are stable while enable is high; a pending
// character is only taken in the idle state, so each frame gets a full lead.
module uart_de_seq #(
    parameter int DATA_W = 9,
    parameter int DLY_W  = 5,
    parameter int BIT_W  = 4,
    parameter int OS_MAX = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick,
    input  logic [BIT_W-1:0]        nbits,
    input  logic                    os8,
    input  logic                    stop2,
    input  logic [DLY_W-1:0]        lead,
    input  logic [DLY_W-1:0]        lag,
    input  logic                    hold_vld,
    input  logic [DATA_W-1:0]       hold_data,
    output logic                    pop,
    output uart_de_pkg::seq_state_t state,
    output logic                    tx,
    output logic                    de
);
    import uart_de_pkg::*;

    localparam int SUB_W = $clog2(OS_MAX);

    logic [SUB_W-1:0]  sub;
    logic [BIT_W-1:0]  bitc;
    logic [DLY_W-1:0]  dcnt;
    logic [DATA_W-1:0] shreg;
    logic [SUB_W-1:0]  sub_last;
    logic              bit_end;
    logic [BIT_W-1:0]  stop_last;

    // Per-bit tick limit and stop-bit limit from the captured settings
    always_comb begin
        sub_last  = os8 ? SUB_W'(OS_MAX / 2 - 1) : SUB_W'(OS_MAX - 1);
        bit_end   = tick && (sub == sub_last);
        stop_last = stop2 ? BIT_W'(1) : BIT_W'(0);
    end

    // Sequencer state, counters and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
            sub   <= '0;
            bitc  <= '0;
            dcnt  <= '0;
            shreg <= '1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (hold_vld) begin
                        shreg <= hold_data;
                        sub   <= '0;
                        bitc  <= '0;
                        dcnt  <= '0;
                        state <= (lead == '0) ? ST_START : ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (dcnt == lead - DLY_W'(1)) begin
                            state <= ST_START;
                            sub   <= '0;
                        end else begin
                            dcnt <= dcnt + DLY_W'(1);
                        end
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state <= ST_DATA;
                        sub   <= '0;
                        bitc  <= '0;
                    end else if (tick) begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        sub   <= '0;
                        shreg <= {1'b1, shreg[DATA_W-1:1]};
                        if (bitc == nbits - BIT_W'(1)) begin
                            state <= ST_STOP;
                            bitc  <= '0;
                        end else begin
                            bitc <= bitc + BIT_W'(1);
                        end
                    end else if (tick) begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        sub <= '0;
                        if (bitc == stop_last) begin
                            bitc  <= '0;
                            dcnt  <= '0;
                            state <= (lag == '0) ? ST_IDLE : ST_LAG;
                        end else begin
                            bitc <= bitc + BIT_W'(1);
                        end
                    end else if (tick) begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                ST_LAG: begin
                    if (tick) begin
                        if (dcnt == lag - DLY_W'(1)) begin
                            state <= ST_IDLE;
                        end else begin
                            dcnt <= dcnt + DLY_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line level, driver enable and hand-off strobe from the current state
    always_comb begin
        pop = enable && (state == ST_IDLE) && hold_vld;
        de  = (state != ST_IDLE);
        case (state)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg[0];
            default:  tx = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_de_tx.sv
// Top of the half-duplex serial transmitter with driver-enable lead and lag.
// Joins configuration capture, the one-entry holding register and the frame
// sequencer, and generates the write-port ready.
// Assumes: tick is a one-clock pulse at 8 or 16 times the bit rate.
module uart_de_tx #(
    parameter int DATA_W = 9,
    parameter int DLY_W  = 5,
    parameter int OS_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_os8,
    input  logic              cfg_stop2,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_lag,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx,
    output logic              de,
    output logic              tx_busy
);
    import uart_de_pkg::*;

    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam int CFG_W = 4 + 2 * DLY_W;

    logic [1:0]        wlen_q;
    logic              os8_q;
    logic              stop2_q;
    logic [DLY_W-1:0]  lead_q;
    logic [DLY_W-1:0]  lag_q;
    logic [BIT_W-1:0]  nbits;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    logic              pop;
    logic              push;
    seq_state_t        state;
    logic [CFG_W-1:0]  cfg_snap;

    uart_de_cfg #(.DLY_W(DLY_W), .BIT_W(BIT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .raw_wlen  (cfg_wlen),
        .raw_os8   (cfg_os8),
        .raw_stop2 (cfg_stop2),
        .raw_lead  (cfg_lead),
        .raw_lag   (cfg_lag),
        .wlen_q    (wlen_q),
        .os8_q     (os8_q),
        .stop2_q   (stop2_q),
        .lead_q    (lead_q),
        .lag_q     (lag_q),
        .nbits     (nbits)
    );

    uart_de_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .vld       (hold_vld),
        .data      (hold_data)
    );

    uart_de_seq #(
        .DATA_W (DATA_W),
        .DLY_W  (DLY_W),
        .BIT_W  (BIT_W),
        .OS_MAX (OS_MAX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .nbits     (nbits),
        .os8       (os8_q),
        .stop2     (stop2_q),
        .lead      (lead_q),
        .lag       (lag_q),
        .hold_vld  (hold_vld),
        .hold_data (hold_data),
        .pop       (pop),
        .state     (state),
        .tx        (tx),
        .de        (de)
    );

    // Write-port acceptance and busy indication
    always_comb begin
        wr_ready = enable && !hold_vld && ((state == ST_IDLE) || (state == ST_LAG));
        push     = wr_valid && wr_ready;
        tx_busy  = de;
        cfg_snap = {wlen_q, os8_q, stop2_q, lead_q, lag_q};
    end

endmodule

// File: rtl/uart_de_tx_chk.sv
// Property checker for the driver-enable transmitter, bound into the top.
// Assumes: rst_n is synchronous, active low.
module uart_de_tx_chk #(
    parameter int CFG_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tx,
    input logic             de,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             hold_vld,
    input logic [CFG_W-1:0] cfg_snap
);

    // R6
    line_idle_without_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> tx);

    // R11
    disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!de && tx));

    // R8
    accept_fills_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> hold_vld);

    // R8
    ready_blocked_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx |-> !wr_ready);

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_snap));

endmodule

bind uart_de_tx uart_de_tx_chk #(.CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx       (tx),
    .de       (de),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .hold_vld (hold_vld),
    .cfg_snap (cfg_snap)
);

// File: tb/uart_de_tx_tb.sv
`timescale 1ns/1ps
// Directed bench for the driver-enable transmitter; tick runs every clock
// unless a test stops it, so tick counts equal clock counts.
module uart_de_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] cfg_wlen = 2'b00;
    logic       cfg_os8 = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic [4:0] cfg_lead = 5'd0;
    logic [4:0] cfg_lag = 5'd0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = 9'd0;
    logic       wr_ready;
    logic       tx;
    logic       de;
    logic       tx_busy;

    int checks = 0;
    int errors = 0;

    uart_de_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .cfg_wlen  (cfg_wlen),
        .cfg_os8   (cfg_os8),
        .cfg_stop2 (cfg_stop2),
        .cfg_lead  (cfg_lead),
        .cfg_lag   (cfg_lag),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .tx        (tx),
        .de        (de),
        .tx_busy   (tx_busy)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] wl, input logic os8, input logic st2,
                             input logic [4:0] ld, input logic [4:0] lg);
        @(negedge clk);
        enable = 1'b0;
        cfg_wlen = wl; cfg_os8 = os8; cfg_stop2 = st2; cfg_lead = ld; cfg_lag = lg;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Offer one character from a negedge; returns on the negedge after acceptance
    task automatic send(input logic [8:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Measure one frame: lead clocks, data bits, and de-high clocks after data.
    // Optionally offers a second character at tail position inj_at.
    task automatic run_frame(input int nb, input int ospb, input bit inj, input int inj_at,
                             input logic [8:0] inj_d, output int lead,
                             output logic [8:0] d, output int tail);
        int guard = 0;
        int mism = 0;
        int linebad = 0;
        lead = 0; d = '0; tail = 0;
        while (!de && guard < 5000) begin @(negedge clk); guard++; end
        while (de && tx) begin
            if (tx_busy != de) mism++;
            lead++;
            @(negedge clk);
        end
        repeat (ospb / 2) @(negedge clk);
        chk(tx == 1'b0, "R2 start bit level", int'(tx), 0);
        chk(wr_ready == 1'b0, "R8 ready low inside frame", int'(wr_ready), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (ospb) @(negedge clk);
            d[i] = tx;
        end
        repeat (ospb - ospb / 2) @(negedge clk);
        while (de) begin
            if (tx_busy != de) mism++;
            if (!tx) linebad++;
            if (inj && tail == inj_at) begin
                chk(wr_ready == 1'b1, "R7 ready during trailing delay", int'(wr_ready), 1);
                wr_valid = 1'b1;
                wr_data  = inj_d;
            end else begin
                wr_valid = 1'b0;
            end
            tail++;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        chk(mism == 0, "R10 busy tracks de", mism, 0);
        chk(linebad == 0, "R2 stop bits and lag at 1", linebad, 0);
    endtask

    task automatic t_reset();
        chk(tx == 1'b1 && de == 1'b0 && tx_busy == 1'b0, "R1 idle after reset",
            int'({tx, de, tx_busy}), 4);
        chk(wr_ready == 1'b0, "R1 ready low while disabled", int'(wr_ready), 0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b1, "R8 ready when enabled and idle", int'(wr_ready), 1);
    endtask

    task automatic t_basic8();
        int ld; int tl; logic [8:0] d;
        configure(2'b00, 1'b0, 1'b0, 5'd3, 5'd2);
        send(9'h0A5);
        chk(wr_ready == 1'b0, "R8 single pending character", int'(wr_ready), 0);
        run_frame(8, 16, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 3, "R5 lead ticks", ld, 3);
        chk(d[7:0] == 8'hA5, "R2 8-bit data LSB first", int'(d[7:0]), 'hA5);
        chk(tl == 18, "R3 R4 R6 16-tick stop plus lag", tl, 18);
    endtask

    task automatic t_nine_os8();
        int ld; int tl; logic [8:0] d;
        configure(2'b01, 1'b1, 1'b1, 5'd0, 5'd0);
        send(9'h1C3);
        run_frame(9, 8, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 0, "R5 zero lead starts with de", ld, 0);
        chk(d == 9'h1C3, "R2 9-bit data", int'(d), 'h1C3);
        chk(tl == 16, "R3 R4 R6 two 8-tick stops, zero lag", tl, 16);
    endtask

    task automatic t_seven();
        int ld; int tl; logic [8:0] d;
        configure(2'b10, 1'b1, 1'b0, 5'd31, 5'd31);
        send(9'h055);
        run_frame(7, 8, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 31, "R5 maximum lead", ld, 31);
        chk(d[6:0] == 7'h55, "R2 7-bit data", int'(d[6:0]), 'h55);
        chk(tl == 39, "R2 R6 stop after 7 bits plus max lag", tl, 39);
    endtask

    task automatic t_cfg_locked();
        int ld; int tl; logic [8:0] d;
        configure(2'b00, 1'b0, 1'b0, 5'd3, 5'd2);
        cfg_lead = 5'd10; cfg_os8 = 1'b1; cfg_lag = 5'd9;
        repeat (3) @(negedge clk);
        send(9'h05A);
        run_frame(8, 16, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 3, "R9 lead unchanged while enabled", ld, 3);
        chk(tl == 18, "R9 timing unchanged while enabled", tl, 18);
        chk(d[7:0] == 8'h5A, "R9 data with held settings", int'(d[7:0]), 'h5A);
    endtask

    task automatic t_write_in_lag();
        int ld; int tl; logic [8:0] d;
        configure(2'b00, 1'b0, 1'b0, 5'd4, 5'd20);
        send(9'h03C);
        run_frame(8, 16, 1'b1, 16, 9'h0F0, ld, d, tl);
        chk(tl == 36, "R7 trailing delay runs to its end", tl, 36);
        chk(de == 1'b0, "R7 de drops between frames", int'(de), 0);
        run_frame(8, 16, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 4, "R7 full lead for queued character", ld, 4);
        chk(d[7:0] == 8'hF0, "R7 queued character data", int'(d[7:0]), 'hF0);
    endtask

    task automatic t_abort();
        int stuck = 0;
        configure(2'b00, 1'b0, 1'b0, 5'd2, 5'd2);
        send(9'h000);
        repeat (40) @(negedge clk);
        chk(tx == 1'b0 && de == 1'b1, "R11 frame in progress before abort",
            int'({tx, de}), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(tx == 1'b1 && de == 1'b0 && tx_busy == 1'b0, "R11 abort returns line idle",
            int'({tx, de, tx_busy}), 4);
        enable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (de) stuck++;
        end
        chk(stuck == 0, "R11 no frame resumes after abort", stuck, 0);
    endtask

    task automatic t_tick_hold();
        int ld; int tl; logic [8:0] d;
        configure(2'b00, 1'b0, 1'b0, 5'd2, 5'd3);
        tick = 1'b0;
        send(9'h081);
        repeat (20) @(negedge clk);
        chk(de == 1'b1 && tx == 1'b1, "R12 lead frozen without tick",
            int'({de, tx}), 3);
        tick = 1'b1;
        run_frame(8, 16, 1'b0, 0, 9'h0, ld, d, tl);
        chk(ld == 2, "R12 lead resumes from where it stopped", ld, 2);
        chk(d[7:0] == 8'h81, "R12 data after resume", int'(d[7:0]), 'h81);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_nine_os8();
        t_seven();
        t_cfg_locked();
        t_write_in_lag();
        t_abort();
        t_tick_hold();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule